// File: doc/BRIEF.md
# Two-Port GPIO Controller with NAND Strobe and Serial Sensor Pin Mapping

This block is a memory-mapped general-purpose I/O controller with two ports, called A and D. Each port has three registers: an output value, an output enable and a read-only input view. They sit in a 92-byte window on a simple 32-bit register bus that accepts only word-aligned accesses. Reads are combinational. A write takes effect at the clock edge on which it is presented.

Fixed bits of the port registers connect straight to two peripherals. Port A output bits drive the address-latch, command-latch and chip-enable strobes of a NAND flash. The NAND ready/busy pin comes back through the port A input view. Port D output bits drive the serial clock and serial data of a three-wire temperature sensor. The sensor's serial output comes back through the port D input view. Both returning pins pass through a synchronizer before they are read.

The other words in the window are plain storage. Software can park values there and read them back.

Top module: `gpio_periph_port`

## Requirements
- R1: After reset, every register reads zero, and every pad output, output enable, NAND strobe and sensor pin is low.
- R2: The word index is the byte address shifted right by 2. Only accesses with address bits [1:0] equal to 0 and a byte address below 0x5C take effect. Any other write changes nothing. Any other read, or an idle bus, returns zero.
- R3: The output registers are at index 0x00 (port A) and 0x10 (port D). The enable registers are at 0x02 (port A) and 0x12 (port D). These, and every other index except 0x01 and 0x11, read back the last value written to them.
- R4: Reading index 0x01 returns (port A output AND port A enable) OR (NAND ready pin at bit 7). The pin value seen is its level from two clock edges earlier.
- R5: Reading index 0x11 returns (port D output AND port D enable) OR (sensor data-out pin at bit 4). The pin passes through the same two-edge synchronizer.
- R6: Writes to the input-view indices 0x01 and 0x11 are ignored.
- R7: The NAND strobes follow the port A output register: address latch is bit 6, command latch is bit 5, chip enable is bit 4. They update at the edge that takes the write.
- R8: The sensor serial clock is bit 1 of the port D output register, and the sensor serial data is bit 4. The clock pin changes only when a write changes bit 1.
- R9: The pad outputs for port A and port D output values and enables mirror their registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 8 | Byte address within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| nandReady | input | 1 | NAND ready/busy pin |
| sensorDout | input | 1 | Sensor serial output pin |
| nandAle | output | 1 | NAND address latch strobe |
| nandCle | output | 1 | NAND command latch strobe |
| nandCe | output | 1 | NAND chip enable |
| sensorClk | output | 1 | Sensor serial clock |
| sensorDin | output | 1 | Sensor serial data |
| portAOut | output | 32 | Port A output value |
| portAOe | output | 32 | Port A output enable |
| portDOut | output | 32 | Port D output value |
| portDOe | output | 32 | Port D output enable |

## Verification
The assertions check on every cycle that:
- misaligned writes and writes to the input views leave all port registers unchanged;
- the NAND strobes take the written bits of the port A output register;
- the sensor clock moves only on a write to the port D output register;
- an input-view read shows no bit that is disabled, except the status pin;
- an idle bus reads zero.

Only the bench's scenarios can show:
- the contents of the full window after sweeps of distinct data patterns;
- the exact two-edge latency of the returning pins;
- that rewriting the same clock level produces no edge;
- that out-of-range addresses read zero.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = ADDR_W - 2;

  localparam logic [IDX_W-1:0] IDX_A_OUT = 6'h00;
  localparam logic [IDX_W-1:0] IDX_A_IN  = 6'h01;
  localparam logic [IDX_W-1:0] IDX_A_OE  = 6'h02;
  localparam logic [IDX_W-1:0] IDX_D_OUT = 6'h10;
  localparam logic [IDX_W-1:0] IDX_D_IN  = 6'h11;
  localparam logic [IDX_W-1:0] IDX_D_OE  = 6'h12;

  localparam int BIT_NAND_RDY = 7;
  localparam int BIT_ALE      = 6;
  localparam int BIT_CLE      = 5;
  localparam int BIT_CE       = 4;
  localparam int BIT_SCLK     = 1;
  localparam int BIT_SDAT     = 4;
  localparam int BIT_SDO      = 4;

  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic [IDX_W-1:0] idx;
  } regStrobes_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic pinSync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= pinIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign pinSync = chain[STAGES-1];
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_WORDS = 23
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobes_t       strobes
);
  logic             aligned;
  logic             inRange;
  logic             isInView;
  logic [IDX_W-1:0] wordIdx;

  always_comb begin
    wordIdx  = busAddr[ADDR_W-1:2];
    aligned  = (busAddr[1:0] == 2'b00);
    inRange  = ({1'b0, wordIdx} < (IDX_W+1)'(NUM_WORDS));
    isInView = (wordIdx == IDX_A_IN) || (wordIdx == IDX_D_IN);

    strobes.idx  = wordIdx;
    strobes.wrEn = busSel && busWrite && aligned && inRange && !isInView;
    strobes.rdEn = busSel && !busWrite && aligned && inRange;
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int NUM_WORDS   = 23,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              nandReady,
  input  logic              sensorDout,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] portAOut,
  output logic [DATA_W-1:0] portAOe,
  output logic [DATA_W-1:0] portDOut,
  output logic [DATA_W-1:0] portDOe
);
  logic [DATA_W-1:0] regWord [NUM_WORDS];
  logic              rdySync;
  logic              sdoSync;

  gpio_sync #(.STAGES(SYNC_STAGES)) uRdySync (
    .clk(clk), .rstN(rstN), .pinIn(nandReady), .pinSync(rdySync)
  );
  gpio_sync #(.STAGES(SYNC_STAGES)) uSdoSync (
    .clk(clk), .rstN(rstN), .pinIn(sensorDout), .pinSync(sdoSync)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
    localparam bit IS_VIEW = (w == int'(IDX_A_IN)) || (w == int'(IDX_D_IN));
    if (IS_VIEW) begin : gView
      assign regWord[w] = '0;
    end else begin : gStore
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regWord[w] <= '0;
        else if (strobes.wrEn && strobes.idx == IDX_W'(w)) regWord[w] <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdEn) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (strobes.idx == IDX_W'(w)) rdData = regWord[w];
      end
      if (strobes.idx == IDX_A_IN)
        rdData = (regWord[IDX_A_OUT] & regWord[IDX_A_OE])
               | (DATA_W'(rdySync) << BIT_NAND_RDY);
      if (strobes.idx == IDX_D_IN)
        rdData = (regWord[IDX_D_OUT] & regWord[IDX_D_OE])
               | (DATA_W'(sdoSync) << BIT_SDO);
    end
  end

  assign portAOut = regWord[IDX_A_OUT];
  assign portAOe  = regWord[IDX_A_OE];
  assign portDOut = regWord[IDX_D_OUT];
  assign portDOe  = regWord[IDX_D_OE];

  // R4: no disabled bit other than the status pin leaks into the input view
  assert_view_masked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdEn && strobes.idx == IDX_A_IN) |->
      ((rdData & ~portAOe & ~(DATA_W'(1) << BIT_NAND_RDY)) == '0));
  // R5: same for port D
  assert_view_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdEn && strobes.idx == IDX_D_IN) |->
      ((rdData & ~portDOe & ~(DATA_W'(1) << BIT_SDO)) == '0));
endmodule

// File: rtl/gpio_periph_port.sv
module gpio_periph_port
  import gpio_pkg::*;
#(
  parameter int WINDOW_BYTES = 92,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              nandReady,
  input  logic              sensorDout,
  output logic              nandAle,
  output logic              nandCle,
  output logic              nandCe,
  output logic              sensorClk,
  output logic              sensorDin,
  output logic [DATA_W-1:0] portAOut,
  output logic [DATA_W-1:0] portAOe,
  output logic [DATA_W-1:0] portDOut,
  output logic [DATA_W-1:0] portDOe
);
  localparam int NUM_WORDS = WINDOW_BYTES / 4;

  regStrobes_t strobes;

  gpio_ctrl #(.NUM_WORDS(NUM_WORDS)) uCtrl (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .strobes(strobes)
  );

  gpio_datapath #(.NUM_WORDS(NUM_WORDS), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(busWdata),
    .nandReady(nandReady), .sensorDout(sensorDout), .rdData(busRdata),
    .portAOut(portAOut), .portAOe(portAOe), .portDOut(portDOut), .portDOe(portDOe)
  );

  assign nandAle   = portAOut[BIT_ALE];
  assign nandCle   = portAOut[BIT_CLE];
  assign nandCe    = portAOut[BIT_CE];
  assign sensorClk = portDOut[BIT_SCLK];
  assign sensorDin = portDOut[BIT_SDAT];

  logic wrAny;
  assign wrAny = busSel && busWrite;

  // R2: misaligned writes change no port register
  assert_misaligned_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrAny && busAddr[1:0] != 2'b00) |=>
      ($stable(portAOut) && $stable(portAOe) && $stable(portDOut) && $stable(portDOe)));
  // R2: idle bus reads zero
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (busRdata == '0));
  // R6: writes to input views change no port register
  assert_view_write_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrAny && (busAddr == {IDX_A_IN, 2'b00} || busAddr == {IDX_D_IN, 2'b00})) |=>
      ($stable(portAOut) && $stable(portAOe) && $stable(portDOut) && $stable(portDOe)));
  // R7: strobes take the written bits
  assert_strobes_follow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrAny && busAddr == {IDX_A_OUT, 2'b00}) |=>
      (nandAle == $past(busWdata[BIT_ALE]) && nandCle == $past(busWdata[BIT_CLE])
       && nandCe == $past(busWdata[BIT_CE])));
  // R8: sensor clock moves only on a port D output write
  assert_sclk_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(wrAny && busAddr == {IDX_D_OUT, 2'b00}) |=> $stable(sensorClk));
endmodule

// File: tb/tb_gpio_periph_port.sv
module tb_gpio_periph_port;
  localparam int NW = 23;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        nandReady = 1'b0, sensorDout = 1'b0;
  logic        nandAle, nandCle, nandCe, sensorClk, sensorDin;
  logic [31:0] portAOut, portAOe, portDOut, portDOe;

  gpio_periph_port dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .nandReady(nandReady),
    .sensorDout(sensorDout), .nandAle(nandAle), .nandCle(nandCle), .nandCe(nandCe),
    .sensorClk(sensorClk), .sensorDin(sensorDin), .portAOut(portAOut),
    .portAOe(portAOe), .portDOut(portDOut), .portDOe(portDOe)
  );

  always #4 clk = ~clk;

  int nVec = 0, nFail = 0, edgeCnt = 0;
  bit finished = 0;
  logic [31:0] mdl [NW];

  always @(sensorClk) if (rstN === 1'b1) edgeCnt++;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic doRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 check(busRdata, exp, tag);
    busSel = 0;
  endtask

  function automatic logic [31:0] expRead(input int idx);
    if (idx == 1) return (mdl[0] & mdl[2]) | (32'(nandReady) << 7);
    if (idx == 17) return (mdl[16] & mdl[18]) | (32'(sensorDout) << 4);
    return mdl[idx];
  endfunction

  function automatic logic [31:0] pat(input int k);
    return (32'h9E3779B9 * 32'(k + 1)) ^ (32'(k) << 7) ^ 32'h0000_A5A5;
  endfunction

  task automatic checkPins(input string tag);
    check({29'd0, nandAle, nandCle, nandCe}, {29'd0, mdl[0][6], mdl[0][5], mdl[0][4]}, {"R7 strobes ", tag});
    check({30'd0, sensorClk, sensorDin}, {30'd0, mdl[16][1], mdl[16][4]}, {"R8 sensor pins ", tag});
    check(portAOut, mdl[0], {"R9 portAOut ", tag});
    check(portAOe,  mdl[2], {"R9 portAOe ", tag});
    check(portDOut, mdl[16], {"R9 portDOut ", tag});
    check(portDOe,  mdl[18], {"R9 portDOe ", tag});
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    checkPins("R1 reset");
    for (int i = 0; i < NW; i++) doRead(8'(i * 4), 32'h0, "R1 reset readback");

    // Sweep: four rounds of patterns over the whole window (R3 R4 R5 R6 R7 R9)
    for (int r = 0; r < 4; r++) begin
      nandReady = r[0]; sensorDout = r[1];
      for (int i = 0; i < NW; i++) begin
        logic [31:0] d;
        d = pat(r * NW + i);
        if (r == 3) d = ~d;
        doWrite(8'(i * 4), d);
        if (i != 1 && i != 17) mdl[i] = d; // R6: views not stored
        checkPins("sweep");
      end
      for (int i = 0; i < NW; i++) begin
        if (i == 1) doRead(8'(i * 4), expRead(i), "R4 port A view");
        else if (i == 17) doRead(8'(i * 4), expRead(i), "R5 port D view");
        else doRead(8'(i * 4), expRead(i), "R3 readback / R6 view write ignored");
      end
    end

    // R2: misaligned and out-of-range accesses
    for (int k = 1; k < 4; k++) doWrite(8'(k), 32'hFFFF_FFFF);
    doWrite(8'h41, 32'hFFFF_FFFF);
    doWrite(8'h5C, 32'hFFFF_FFFF);
    doWrite(8'hFC, 32'hFFFF_FFFF);
    checkPins("R2 after bad writes");
    doRead(8'h00, mdl[0], "R2 word0 untouched");
    doRead(8'h40, mdl[16], "R2 word16 untouched");
    doRead(8'h01, 32'h0, "R2 misaligned read");
    doRead(8'h5C, 32'h0, "R2 out-of-range read");
    doRead(8'h60, 32'h0, "R2 out-of-range read");
    doRead(8'hFC, 32'h0, "R2 out-of-range read");

    // R8: clock edges only on change of bit 1
    begin
      int base;
      doWrite(8'h40, 32'h0000_0000); mdl[16] = 32'h0;
      base = edgeCnt;
      doWrite(8'h40, 32'h0000_0010); mdl[16] = 32'h10;
      doWrite(8'h40, 32'h0000_F000); mdl[16] = 32'hF000;
      check(32'(edgeCnt - base), 32'd0, "R8 no edge when bit1 unchanged");
      doWrite(8'h40, 32'h0000_0012); mdl[16] = 32'h12;
      check(32'(edgeCnt - base), 32'd1, "R8 rising edge");
      check({31'd0, sensorDin}, 32'd1, "R8 data bit4");
      doWrite(8'h40, 32'h0000_0002); mdl[16] = 32'h2;
      check(32'(edgeCnt - base), 32'd1, "R8 rewrite same level no edge");
      doWrite(8'h00, 32'h0000_0002); mdl[0] = 32'h2;
      doWrite(8'h48, 32'h0000_0000); mdl[18] = 32'h0;
      check(32'(edgeCnt - base), 32'd1, "R8 other writes no edge");
      doWrite(8'h40, 32'h0000_0000); mdl[16] = 32'h0;
      check(32'(edgeCnt - base), 32'd2, "R8 falling edge");
    end

    // R4/R5: two-edge synchronizer latency, enables cleared
    doWrite(8'h08, 32'h0); mdl[2] = 32'h0;
    doWrite(8'h48, 32'h0); mdl[18] = 32'h0;
    @(negedge clk); nandReady = 0; sensorDout = 0;
    repeat (3) @(negedge clk);
    nandReady = 1; sensorDout = 1;
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = 8'h04;
    #1 check(busRdata, 32'h0, "R4 ready not yet visible after one edge");
    busAddr = 8'h44;
    #1 check(busRdata, 32'h0, "R5 sdo not yet visible after one edge");
    @(negedge clk);
    busAddr = 8'h04;
    #1 check(busRdata, 32'h0000_0080, "R4 ready visible after two edges");
    busAddr = 8'h44;
    #1 check(busRdata, 32'h0000_0010, "R5 sdo visible after two edges");
    busSel = 0;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule